// File: doc/BRIEF.md
# SPI Master Chip-Select Controller

This block sits between the transmit-data path of an SPI master and its four active-low chip-select pins. For every accepted transmit word it works out a 4-bit peripheral code. The code comes either from a fixed code input or from a field inside the word. The block then drives the select pins, reports which of four per-slave configuration slots applies, and passes that slot's character length and the word's data to the serial shifter.

The pins can be driven in two ways. In one-hot form, at most one line is ever low. In decode form, the raw code goes to an external decoder that can address up to fifteen slaves. The selects stay high while nothing is being sent. They fall back high when a word marked as last has finished, or when a word finishes and no further word is waiting.

Top module: `spi_csel_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `cs_n_o` is 4'hF, `sh_start_o` is 0, `cfg_idx_o` is 0 and `tx_ready_o` is 1.
- R2: With `sel_var_i` = 0, the peripheral code is `fix_code_i`, and bits [19:16] of the transmit word have no effect on the outputs.
- R3: With `sel_var_i` = 1, the peripheral code is transmit-word bits [19:16], bit 24 is the last-word flag, and bits [15:0] appear on `sh_data_o` when the word starts.
- R4: With `dec_en_i` = 0, `cs_n_o` has exactly one low bit, at the position of the lowest zero bit of the code (code 5 gives 4'b1101).
- R5: With `dec_en_i` = 1, `cs_n_o` equals the code itself (code 9 gives 4'b1001).
- R6: `cfg_idx_o` is code[3:2] when `dec_en_i` = 1, and the position of the lowest zero bit of the code when `dec_en_i` = 0.
- R7: `char_len_o` is the 5-bit field `slot_len_i[5*idx +: 5]` of the selected slot, limited to the range 8 to 16.
- R8: A word whose code is 4'hF is consumed when offered, but it starts nothing and does not pull any select low.
- R9: A word accepted on a clock edge (`tx_valid_i` and `tx_ready_o` both high) sets `cs_n_o`, `cfg_idx_o`, `char_len_o` and `sh_data_o` after that edge. It also pulses `sh_start_o` for exactly one cycle. These outputs then stay stable until `sh_done_i`.
- R10: On a `sh_done_i` cycle, the selects go to 4'hF on the next cycle if the finishing word had its last flag set or no word is offered. When the last flag is set, `tx_ready_o` is low during that cycle even if a word is offered.
- R11: On a `sh_done_i` cycle for a word without the last flag, `tx_ready_o` is high. An offered word then starts on the next cycle without the selects passing through 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_var_i | input | 1 | 1: code from each word, 0: code from `fix_code_i` |
| dec_en_i | input | 1 | 1: raw code on pins, 0: one-hot selects |
| fix_code_i | input | 4 | Fixed peripheral code |
| slot_len_i | input | 20 | Four 5-bit character lengths, slot 0 in bits [4:0] |
| tx_word_i | input | 32 | Transmit word: data [15:0], code [19:16], last flag [24] |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Transmit word can be taken this cycle |
| sh_start_o | output | 1 | One-cycle start strobe to the shifter |
| sh_data_o | output | 16 | Data for the shifter |
| sh_done_i | input | 1 | Shifter finished the current word |
| cs_n_o | output | 4 | Active-low chip-select pins |
| cfg_idx_o | output | 2 | Selected configuration slot |
| char_len_o | output | 5 | Character length of the selected slot |

## Verification
Some properties are checked by assertions on every cycle. The selects are all high whenever no word is in flight. A one-hot start never shows more than one low line. The start strobe lasts one cycle, and the length it carries is within 8 to 16. Selects and slot index hold steady until the shifter reports done, and the selects are released when done arrives with nothing offered.

The code sources, the lowest-zero priority, the decode mapping of codes to slots, the dropping of code 4'hF and the last-flag handover depend on chosen stimulus. Only the bench's scenarios show those, through its per-clock reference model and its named checks.

// File: rtl/spi_csel_ctrl.sv
module spi_csel_ctrl #(
  parameter int WORD_W   = 32,
  parameter int DATA_W   = 16,
  parameter int CODE_LSB = 16,
  parameter int LAST_BIT = 24,
  parameter int LEN_W    = 5,
  parameter int MIN_LEN  = 8,
  parameter int MAX_LEN  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_var_i,
  input  logic                dec_en_i,
  input  logic [3:0]          fix_code_i,
  input  logic [4*LEN_W-1:0]  slot_len_i,
  input  logic [WORD_W-1:0]   tx_word_i,
  input  logic                tx_valid_i,
  output logic                tx_ready_o,
  output logic                sh_start_o,
  output logic [DATA_W-1:0]   sh_data_o,
  input  logic                sh_done_i,
  output logic [3:0]          cs_n_o,
  output logic [1:0]          cfg_idx_o,
  output logic [LEN_W-1:0]    char_len_o
);
  localparam logic [3:0] IDLE_CODE = 4'hF;

  logic             busy_q, last_q;
  logic [3:0]       code_w;
  logic [1:0]       low_zero, idx_w;
  logic [LEN_W-1:0] raw_len, len_w;
  logic             take, go;

  assign code_w = sel_var_i ? tx_word_i[CODE_LSB +: 4] : fix_code_i;

  always_comb begin
    low_zero = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (!code_w[i]) low_zero = 2'(i);
  end

  assign idx_w   = dec_en_i ? code_w[3:2] : low_zero;
  assign raw_len = slot_len_i[idx_w*LEN_W +: LEN_W];
  assign len_w   = (raw_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) :
                   (raw_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : raw_len;

  assign tx_ready_o = !busy_q || (sh_done_i && !last_q);
  assign take       = tx_valid_i && tx_ready_o;
  assign go         = take && (code_w != IDLE_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      last_q     <= 1'b0;
      sh_start_o <= 1'b0;
      sh_data_o  <= '0;
      cs_n_o     <= IDLE_CODE;
      cfg_idx_o  <= '0;
      char_len_o <= LEN_W'(MIN_LEN);
    end else begin
      sh_start_o <= 1'b0;
      if (go) begin
        busy_q     <= 1'b1;
        last_q     <= tx_word_i[LAST_BIT];
        sh_start_o <= 1'b1;
        sh_data_o  <= tx_word_i[DATA_W-1:0];
        cs_n_o     <= dec_en_i ? code_w : ~(4'b0001 << low_zero);
        cfg_idx_o  <= idx_w;
        char_len_o <= len_w;
      end else if (busy_q && sh_done_i) begin
        busy_q <= 1'b0;
        last_q <= 1'b0;
        cs_n_o <= IDLE_CODE;
      end
    end
  end
endmodule

// File: rtl/spi_csel_ctrl_chk.sv
module spi_csel_ctrl_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             sh_start_o,
  input logic             sh_done_i,
  input logic             tx_valid_i,
  input logic             dec_en_i,
  input logic [3:0]       cs_n_o,
  input logic [1:0]       cfg_idx_o,
  input logic [LEN_W-1:0] char_len_o
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n_o == 4'hF);

  assert_single_low_R4: assert property (@(posedge clk) disable iff (rst)
    (sh_start_o && !$past(dec_en_i)) |-> $onehot0(~cs_n_o));

  assert_len_range_R7: assert property (@(posedge clk) disable iff (rst)
    sh_start_o |-> (char_len_o >= LEN_W'(8) && char_len_o <= LEN_W'(16)));

  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    sh_start_o |=> !sh_start_o);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !sh_done_i) |=> ($stable(cs_n_o) && $stable(cfg_idx_o)));

  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && sh_done_i && !tx_valid_i) |=> cs_n_o == 4'hF);
endmodule

bind spi_csel_ctrl spi_csel_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_q), .sh_start_o(sh_start_o),
  .sh_done_i(sh_done_i), .tx_valid_i(tx_valid_i), .dec_en_i(dec_en_i),
  .cs_n_o(cs_n_o), .cfg_idx_o(cfg_idx_o), .char_len_o(char_len_o)
);

// File: tb/test_spi_csel_ctrl.sv
module test_spi_csel_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        sel_var_i = 0, dec_en_i = 0, tx_valid_i = 0, sh_done_i = 0;
  logic [3:0]  fix_code_i = 0;
  logic [19:0] slot_len_i = {5'd20, 5'd12, 5'd10, 5'd3};
  logic [31:0] tx_word_i = 0;
  logic        tx_ready_o, sh_start_o;
  logic [15:0] sh_data_o;
  logic [3:0]  cs_n_o;
  logic [1:0]  cfg_idx_o;
  logic [4:0]  char_len_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done_run = 0;

  spi_csel_ctrl i_spi_csel_ctrl (
    .clk(clk), .rst(rst), .sel_var_i(sel_var_i), .dec_en_i(dec_en_i),
    .fix_code_i(fix_code_i), .slot_len_i(slot_len_i), .tx_word_i(tx_word_i),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .sh_start_o(sh_start_o),
    .sh_data_o(sh_data_o), .sh_done_i(sh_done_i), .cs_n_o(cs_n_o),
    .cfg_idx_o(cfg_idx_o), .char_len_o(char_len_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] code, input logic last, input logic [15:0] d);
    return {7'b0, last, 4'b0, code, d};
  endfunction

  // reference model
  bit        m_busy, m_last, m_start;
  int        m_cs = 15, m_idx = 0, m_len = 8, m_data = 0;

  function automatic bit m_ready();
    return !m_busy || (sh_done_i && !m_last);
  endfunction

  always @(posedge clk) begin
    int code, pos, slen;
    if (rst) begin
      m_busy = 0; m_last = 0; m_start = 0; m_cs = 15; m_idx = 0; m_len = 8; m_data = 0;
    end else begin
      bit acc;
      acc = tx_valid_i && m_ready();
      code = sel_var_i ? int'(tx_word_i[19:16]) : int'(fix_code_i);
      m_start = 0;
      if (acc && code != 15) begin
        pos = 0;
        while (((code >> pos) & 1) == 1) pos++;
        m_idx  = dec_en_i ? code / 4 : pos;
        m_cs   = dec_en_i ? code : (15 - (1 << pos));
        slen   = (slot_len_i >> (5 * m_idx)) & 31;
        m_len  = slen < 8 ? 8 : (slen > 16 ? 16 : slen);
        m_data = int'(tx_word_i[15:0]);
        m_last = tx_word_i[24];
        m_busy = 1; m_start = 1;
      end else if (m_busy && sh_done_i) begin
        m_busy = 0; m_last = 0; m_cs = 15;
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (!rst && !done_run) begin
      chk(int'(cs_n_o) == m_cs, dec_en_i ? "R5 model cs" : "R4 model cs", cs_n_o, m_cs);
      chk(int'(cfg_idx_o) == m_idx, "R6 model idx", cfg_idx_o, m_idx);
      chk(int'(char_len_o) == m_len, "R7 model len", char_len_o, m_len);
      chk(sh_start_o == m_start, "R9 model start", sh_start_o, m_start);
      chk(tx_ready_o == m_ready(), "R10 model ready", tx_ready_o, m_ready());
      chk(int'(sh_data_o) == m_data, "R3 model data", sh_data_o, m_data);
    end
  end

  task automatic finish_run();
    done_run = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 3000 && !done_run) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<3000", cyc);
      finish_run();
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    tick(); tick();
    chk(cs_n_o == 4'hF && !sh_start_o, "R1 reset cs", cs_n_o, 15);
    rst = 0;
    tick();
    chk(cs_n_o == 4'hF && cfg_idx_o == 0 && tx_ready_o, "R1 after reset", cs_n_o, 15);

    // fixed one-hot, word code ignored
    fix_code_i = 4'h5; tx_word_i = mk(4'h0, 1, 16'h1234); tx_valid_i = 1;
    tick(); tx_valid_i = 0;
    chk(cs_n_o == 4'b1101, "R2 fixed code cs", cs_n_o, 4'b1101);
    chk(cfg_idx_o == 1, "R6 one-hot idx", cfg_idx_o, 1);
    chk(char_len_o == 10, "R7 slot1 len", char_len_o, 10);
    chk(sh_data_o == 16'h1234, "R3 data", sh_data_o, 16'h1234);
    chk(sh_start_o, "R9 start", sh_start_o, 1);
    tick();
    chk(!sh_start_o && cs_n_o == 4'b1101, "R9 one pulse, hold", cs_n_o, 4'b1101);
    sh_done_i = 1; #1;
    chk(!tx_ready_o, "R10 ready low on last", tx_ready_o, 0);
    tick(); sh_done_i = 0;
    chk(cs_n_o == 4'hF, "R10 release", cs_n_o, 15);

    // variable decode, back-to-back
    sel_var_i = 1; dec_en_i = 1; tx_word_i = mk(4'h9, 0, 16'h00A5); tx_valid_i = 1;
    tick(); tx_valid_i = 0;
    chk(cs_n_o == 4'b1001, "R5 raw code", cs_n_o, 4'b1001);
    chk(cfg_idx_o == 2 && char_len_o == 12, "R6 decode idx", cfg_idx_o, 2);
    tick();
    sh_done_i = 1; tx_word_i = mk(4'hE, 1, 16'h5A5A); tx_valid_i = 1; #1;
    chk(tx_ready_o, "R11 ready at done", tx_ready_o, 1);
    tick(); sh_done_i = 0; tx_valid_i = 0;
    chk(cs_n_o == 4'b1110 && sh_start_o, "R11 next word no gap", cs_n_o, 4'b1110);
    chk(char_len_o == 16, "R7 clamp high", char_len_o, 16);
    sh_done_i = 1; tick(); sh_done_i = 0;
    chk(cs_n_o == 4'hF, "R10 release after last", cs_n_o, 15);

    // clamp low
    tx_word_i = mk(4'h2, 1, 16'h0001); tx_valid_i = 1;
    tick(); tx_valid_i = 0;
    chk(char_len_o == 8 && cs_n_o == 4'b0010, "R7 clamp low", char_len_o, 8);
    sh_done_i = 1; tick(); sh_done_i = 0;

    // idle code dropped
    tx_word_i = mk(4'hF, 0, 16'hFFFF); tx_valid_i = 1;
    tick();
    chk(cs_n_o == 4'hF && !sh_start_o, "R8 code F decode", cs_n_o, 15);
    dec_en_i = 0; tick(); tx_valid_i = 0;
    chk(cs_n_o == 4'hF && !sh_start_o && tx_ready_o, "R8 code F one-hot", cs_n_o, 15);

    // last flag beats pending word
    tx_word_i = mk(4'h3, 1, 16'h0303); tx_valid_i = 1;
    tick(); tx_valid_i = 0;
    chk(cs_n_o == 4'b1011 && cfg_idx_o == 2, "R4 lowest zero", cs_n_o, 4'b1011);
    sh_done_i = 1; tx_word_i = mk(4'h1, 1, 16'h0101); tx_valid_i = 1; #1;
    chk(!tx_ready_o, "R10 ready low with pending", tx_ready_o, 0);
    tick(); sh_done_i = 0;
    chk(cs_n_o == 4'hF && !sh_start_o, "R10 released despite pending", cs_n_o, 15);
    tick(); tx_valid_i = 0;
    chk(cs_n_o == 4'b1101 && cfg_idx_o == 1, "R4 pending word starts", cs_n_o, 4'b1101);
    sh_done_i = 1; tick(); sh_done_i = 0;
    tick(); tick();
    chk(cs_n_o == 4'hF, "R1 idle at end", cs_n_o, 15);
    finish_run();
  end
endmodule